// File: doc/BRIEF.md
# Descriptor Submission Ring

This block is a per-channel queue of transfer descriptors. It sits between a 32-bit register bus and a transfer engine. Software builds each descriptor by writing four 32-bit words in a row to one fixed port offset: address low, address high, byte length, then flags. The ring holds four complete descriptors. The engine takes them out in arrival order through a valid/ready pop interface, one whole descriptor per handshake.

Software sees the ring through a status word. It holds the raw write and read slot indices, separate empty and full flags, and a sticky error flag. Misuse never corrupts stored entries. Committing a descriptor into a full ring sets the error flag, and so does popping an empty one. A one-cycle event pulse is raised toward the interrupt logic whenever this happens. The ring can be flushed in two ways: by a level-held bit in a control word, or by a dedicated input pin.

Top module: `desc_submit_ring`

## Requirements
- R1: After synchronous reset, `ring_status` reads 0x100 (empty set, both slot indices 0, full and error clear), `pop_valid` is 0 and `err_evt` is 0.
- R2: Four writes to the port offset 0x0 form one descriptor: address bits [31:0], then address bits [63:32], then the length, then the flags word. The write slot and the occupancy change only on the fourth write, one clock after it.
- R3: While the ring is not empty, `pop_valid` is 1 and the pop outputs show the oldest descriptor. `pop_notify` equals bit 16 of its flags word. A cycle with `pop_ready` and `pop_valid` both high removes that descriptor and advances the read slot by one.
- R4: The status word at offset 0x4 holds the write slot in bits [1:0], the read slot in bits [5:4], empty in bit 8, full in bit 9 and error in bit 10. All other bits are zero. When the two slot indices are equal, exactly one of empty and full is set.
- R5: The ring holds 4 descriptors. Both slot indices wrap from 3 to 0, and descriptors leave in the order their fourth words arrived, across the wrap.
- R6: A fourth word that arrives while the ring is full (judged before any pop in the same cycle) sets the error flag. That descriptor is dropped and the stored entries and the write slot stay unchanged.
- R7: `pop_ready` while the ring is empty and not being flushed sets the error flag and changes nothing else.
- R8: The error flag is sticky. A write of 1 to status bit 10 clears it. A status write with bit 10 at 0 leaves it set. A new error cause in the same cycle as the clearing write wins.
- R9: `err_evt` is high for exactly one cycle, in the cycle after each error cause.
- R10: Writing 1 to bit 0 of the control word at offset 0x8 holds the ring in flush until a 0 is written; the `ring_clr` pin flushes for as long as it is high. During a flush:
  - both slot indices are 0 and the ring is empty;
  - any partial descriptor is discarded;
  - port writes are ignored;
  - `pop_ready` raises no error;
  - the error flag keeps its value.
- R11: When a fourth word commits into a non-full ring in the same cycle as an accepted pop, both take effect and the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| ring_clr | input | 1 | Level flush of the ring |
| ring_status | output | 32 | Status word (slots, empty, full, error) |
| pop_valid | output | 1 | A descriptor is available |
| pop_ready | input | 1 | Engine takes the presented descriptor |
| pop_addr | output | 64 | Descriptor address |
| pop_len | output | 32 | Descriptor byte length |
| pop_flags | output | 32 | Descriptor flags word |
| pop_notify | output | 1 | Completion notification requested |
| err_evt | output | 1 | One-cycle error event |

## Verification
The hardest case to reach is a fourth word that lands in the same cycle as a pop. On a full ring that must still count as an overflow. On an empty ring it is a commit combined with an underflow. The bench reaches both by issuing the final descriptor word with `pop_ready` held in the same cycle. It sweeps every sequence of six operations drawn from push, pop and push-with-pop, starting from a flushed ring, so these collisions occur at every occupancy and across the slot wrap.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int WORD_W         = 32;
  localparam int NOTIFY_BIT     = 16;
  localparam int ST_WR_LSB      = 0;
  localparam int ST_RD_LSB      = 4;
  localparam int ST_EMPTY_BIT   = 8;
  localparam int ST_FULL_BIT    = 9;
  localparam int ST_ERR_BIT     = 10;
  localparam int CTRL_FLUSH_BIT = 0;

  typedef struct packed {
    logic [2*WORD_W-1:0] addr;
    logic [WORD_W-1:0]   len;
    logic [WORD_W-1:0]   flags;
  } desc_t;

  typedef enum logic [1:0] {
    BEAT_ADDR_LO = 2'd0,
    BEAT_ADDR_HI = 2'd1,
    BEAT_LEN     = 2'd2,
    BEAT_FLAGS   = 2'd3
  } beat_e;

endpackage

// File: rtl/dsr_beat_asm.sv
// Collects the four words of a descriptor and flags the cycle of the last one.
module dsr_beat_asm
  import dsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              word_we,
  input  logic [WORD_W-1:0] word_in,
  output logic              commit,
  output desc_t             desc_out
);

  beat_e             beat_q;
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] hi_q;
  logic [WORD_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      beat_q <= BEAT_ADDR_LO;
    end else if (word_we) begin
      beat_q <= beat_e'(beat_q + 2'd1);
    end
  end

  // Staging words carry no reset; they are only read on a commit.
  always_ff @(posedge clk) begin
    if (word_we) begin
      case (beat_q)
        BEAT_ADDR_LO: lo_q  <= word_in;
        BEAT_ADDR_HI: hi_q  <= word_in;
        BEAT_LEN:     len_q <= word_in;
        default:      ;
      endcase
    end
  end

  assign commit         = word_we && (beat_q == BEAT_FLAGS);
  assign desc_out.addr  = {hi_q, lo_q};
  assign desc_out.len   = len_q;
  assign desc_out.flags = word_in;

endmodule

// File: rtl/dsr_slot_mem.sv
// Descriptor storage: one synchronous write port, asynchronous read of the head.
module dsr_slot_mem
  import dsr_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int PTR_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  desc_t            wdata,
  input  logic [PTR_W-1:0] raddr,
  output desc_t            rdata
);

  desc_t mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dsr_ring_ptrs.sv
// Slot indices, occupancy and the overflow / underflow decisions.
module dsr_ring_ptrs #(
  parameter int SLOTS = 4,
  parameter int PTR_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             commit,
  input  logic             pop_req,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic             full,
  output logic             empty,
  output logic             do_write,
  output logic             pop_fire,
  output logic             overflow,
  output logic             underflow
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(SLOTS - 1);
  localparam logic [PTR_W:0]   CAPACITY  = (PTR_W + 1)'(SLOTS);

  logic [PTR_W:0] count_q;

  assign full      = (count_q == CAPACITY);
  assign empty     = (count_q == '0);
  assign do_write  = commit && !full;
  assign overflow  = commit && full;
  assign pop_fire  = pop_req && !empty;
  assign underflow = pop_req && empty;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (do_write) begin
        wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      end
      if (pop_fire) begin
        rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      end
      case ({do_write, pop_fire})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/desc_submit_ring.sv
module desc_submit_ring
  import dsr_pkg::*;
#(
  parameter int              SLOTS    = 4,
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] DESC_OFS = 'h0,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  input  logic                ring_clr,
  output logic [WORD_W-1:0]   ring_status,
  output logic                pop_valid,
  input  logic                pop_ready,
  output logic [2*WORD_W-1:0] pop_addr,
  output logic [WORD_W-1:0]   pop_len,
  output logic [WORD_W-1:0]   pop_flags,
  output logic                pop_notify,
  output logic                err_evt
);

  localparam int PTR_W = $clog2(SLOTS);

  logic             sel_desc, sel_stat, sel_ctrl;
  logic             hold_q, flush_now;
  logic             word_we, pop_req, commit;
  desc_t            new_desc, head_desc;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             full, empty, do_write, pop_fire, overflow, underflow;
  logic             err_q, err_evt_q, err_cause;

  assign sel_desc = bus_we && (bus_addr == DESC_OFS);
  assign sel_stat = bus_we && (bus_addr == STAT_OFS);
  assign sel_ctrl = bus_we && (bus_addr == CTRL_OFS);

  // Level-held flush from the control word.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else if (sel_ctrl) begin
      hold_q <= bus_wdata[CTRL_FLUSH_BIT];
    end
  end

  assign flush_now = hold_q || ring_clr || (sel_ctrl && bus_wdata[CTRL_FLUSH_BIT]);
  assign word_we   = sel_desc && !flush_now;
  assign pop_req   = pop_ready && !flush_now;

  dsr_beat_asm u_asm (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush_now),
    .word_we  (word_we),
    .word_in  (bus_wdata),
    .commit   (commit),
    .desc_out (new_desc)
  );

  dsr_ring_ptrs #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_ptrs (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush_now),
    .commit    (commit),
    .pop_req   (pop_req),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .full      (full),
    .empty     (empty),
    .do_write  (do_write),
    .pop_fire  (pop_fire),
    .overflow  (overflow),
    .underflow (underflow)
  );

  dsr_slot_mem #(.SLOTS(SLOTS), .PTR_W(PTR_W)) u_mem (
    .clk   (clk),
    .we    (do_write),
    .waddr (wr_ptr),
    .wdata (new_desc),
    .raddr (rd_ptr),
    .rdata (head_desc)
  );

  // Sticky error: a new cause takes priority over a write-one-to-clear.
  assign err_cause = overflow || underflow;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= 1'b0;
      err_evt_q <= 1'b0;
    end else begin
      err_evt_q <= err_cause;
      if (err_cause) begin
        err_q <= 1'b1;
      end else if (sel_stat && bus_wdata[ST_ERR_BIT]) begin
        err_q <= 1'b0;
      end
    end
  end

  always_comb begin
    ring_status                         = '0;
    ring_status[ST_WR_LSB +: PTR_W]     = wr_ptr;
    ring_status[ST_RD_LSB +: PTR_W]     = rd_ptr;
    ring_status[ST_EMPTY_BIT]           = empty;
    ring_status[ST_FULL_BIT]            = full;
    ring_status[ST_ERR_BIT]             = err_q;
  end

  assign pop_valid  = !empty;
  assign pop_addr   = head_desc.addr;
  assign pop_len    = head_desc.len;
  assign pop_flags  = head_desc.flags;
  assign pop_notify = head_desc.flags[NOTIFY_BIT];
  assign err_evt    = err_evt_q;

  // pop_fire is consumed inside the pointer block; kept visible for the checker.
  logic unused_ok;
  assign unused_ok = pop_fire;

endmodule

// File: rtl/desc_submit_ring_chk.sv
module desc_submit_ring_chk
  import dsr_pkg::*;
#(
  parameter int                SLOTS    = 4,
  parameter int                ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h4
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] ring_status,
  input logic              pop_valid,
  input logic              pop_ready,
  input logic              err_evt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic              flush_now
);

  localparam int PTR_W = $clog2(SLOTS);

  logic [PTR_W-1:0] wr_s, rd_s;
  logic             st_empty, st_full, st_err, clr_err;

  assign wr_s     = ring_status[ST_WR_LSB +: PTR_W];
  assign rd_s     = ring_status[ST_RD_LSB +: PTR_W];
  assign st_empty = ring_status[ST_EMPTY_BIT];
  assign st_full  = ring_status[ST_FULL_BIT];
  assign st_err   = ring_status[ST_ERR_BIT];
  assign clr_err  = bus_we && (bus_addr == STAT_OFS) && bus_wdata[ST_ERR_BIT];

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(st_full && st_empty)); // R4

  AST_EQUAL_SLOTS_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (wr_s == rd_s) |-> (st_full || st_empty)); // R4

  AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (pop_ready && pop_valid && !flush_now) |=> (rd_s == PTR_W'($past(rd_s) + 1'b1))); // R3

  AST_EMPTY_POP_ERR: assert property (@(posedge clk) disable iff (rst)
    (pop_ready && !pop_valid && !flush_now) |=> (err_evt && st_err)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (st_full && !pop_ready && !flush_now) |=> $stable(wr_s)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st_err && !clr_err) |=> st_err); // R8

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_now |=> (st_empty && wr_s == '0 && rd_s == '0)); // R10

  AST_EVT_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    err_evt |-> st_err); // R9

endmodule

bind desc_submit_ring desc_submit_ring_chk #(
  .SLOTS    (SLOTS),
  .ADDR_W   (ADDR_W),
  .STAT_OFS (STAT_OFS)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ring_status (ring_status),
  .pop_valid   (pop_valid),
  .pop_ready   (pop_ready),
  .err_evt     (err_evt),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .flush_now   (flush_now)
);

// File: tb/test_desc_submit_ring.sv
`timescale 1ns/1ps
module test_desc_submit_ring;

  localparam int         SLOTS = 4;
  localparam logic [3:0] A_DESC = 4'h0;
  localparam logic [3:0] A_STAT = 4'h4;
  localparam logic [3:0] A_CTRL = 4'h8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        ring_clr = 1'b0;
  logic [31:0] ring_status;
  logic        pop_valid;
  logic        pop_ready = 1'b0;
  logic [63:0] pop_addr;
  logic [31:0] pop_len;
  logic [31:0] pop_flags;
  logic        pop_notify;
  logic        err_evt;

  desc_submit_ring i_desc_submit_ring (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ring_clr    (ring_clr),
    .ring_status (ring_status),
    .pop_valid   (pop_valid),
    .pop_ready   (pop_ready),
    .pop_addr    (pop_addr),
    .pop_len     (pop_len),
    .pop_flags   (pop_flags),
    .pop_notify  (pop_notify),
    .err_evt     (err_evt)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] m_lo [SLOTS];
  logic [31:0] m_hi [SLOTS];
  logic [31:0] m_len [SLOTS];
  logic [31:0] m_fl [SLOTS];
  int m_wr = 0, m_rd = 0, m_cnt = 0;
  bit m_err = 1'b0;
  int seed = 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] e = '0;
    e[1:0] = 2'(m_wr);
    e[5:4] = 2'(m_rd);
    e[8]   = (m_cnt == 0);
    e[9]   = (m_cnt == SLOTS);
    e[10]  = m_err;
    return e;
  endfunction

  task automatic check_all(input string req, input bit evt);
    check({req, " status"}, 64'(ring_status), 64'(exp_status()));
    check({req, " err_evt"}, 64'(err_evt), 64'(evt));
    check({req, " pop_valid"}, 64'(pop_valid), 64'(m_cnt != 0));
    if (m_cnt != 0) begin
      check({req, " addr"}, pop_addr, {m_hi[m_rd], m_lo[m_rd]});
      check({req, " len"}, 64'(pop_len), 64'(m_len[m_rd]));
      check({req, " flags"}, 64'(pop_flags), 64'(m_fl[m_rd]));
      check({req, " notify"}, 64'(pop_notify), 64'(m_fl[m_rd][16]));
    end
  endtask

  task automatic cyc_write(input logic [3:0] a, input logic [31:0] d, input bit with_pop);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; pop_ready = with_pop;
    @(negedge clk);
    bus_we = 1'b0; pop_ready = 1'b0;
  endtask

  task automatic model_push(input string req, input bit with_pop);
    logic [31:0] lo, hi, ln, fl;
    int pre;
    bit evt;
    lo = 32'(seed * 3 + 1);
    hi = 32'hA500_0000 ^ 32'(seed);
    ln = 32'(seed * 16 + 4);
    fl = 32'(seed) | ((seed % 2 == 1) ? 32'h0001_0000 : 32'h0);
    seed++;
    cyc_write(A_DESC, lo, 1'b0);
    cyc_write(A_DESC, hi, 1'b0);
    cyc_write(A_DESC, ln, 1'b0);
    check({req, " R2 no commit before fourth word"}, 64'(ring_status), 64'(exp_status()));
    cyc_write(A_DESC, fl, with_pop);
    pre = m_cnt;
    evt = 1'b0;
    if (with_pop && pre == 0) evt = 1'b1;
    if (pre == SLOTS) begin
      evt = 1'b1;
    end else begin
      m_lo[m_wr] = lo; m_hi[m_wr] = hi; m_len[m_wr] = ln; m_fl[m_wr] = fl;
      m_wr = (m_wr + 1) % SLOTS;
      m_cnt++;
    end
    if (with_pop && pre > 0) begin
      m_rd = (m_rd + 1) % SLOTS;
      m_cnt--;
    end
    if (evt) m_err = 1'b1;
    check_all(req, evt);
  endtask

  task automatic model_pop(input string req);
    bit evt;
    @(negedge clk);
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
    evt = (m_cnt == 0);
    if (m_cnt > 0) begin
      m_rd = (m_rd + 1) % SLOTS;
      m_cnt--;
    end
    if (evt) m_err = 1'b1;
    check_all(req, evt);
  endtask

  task automatic flush_ring();
    cyc_write(A_CTRL, 32'h1, 1'b0);
    cyc_write(A_CTRL, 32'h0, 1'b0);
    m_wr = 0; m_rd = 0; m_cnt = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset status", 64'(ring_status), 64'h100);
    check("R1 reset pop_valid", 64'(pop_valid), 64'h0);
    check("R1 reset err_evt", 64'(err_evt), 64'h0);

    // R5: long alternating run across the slot wrap.
    for (int i = 0; i < 10; i++) begin
      model_push("R5 wrap push", 1'b0);
      model_push("R5 wrap push", 1'b0);
      model_pop("R5 wrap pop");
    end
    flush_ring();
    check_all("R10 flush after wrap", 1'b0);

    // R10: partial descriptor discarded by flush, then a clean one.
    cyc_write(A_DESC, 32'hDEAD_0001, 1'b0);
    cyc_write(A_DESC, 32'hDEAD_0002, 1'b0);
    flush_ring();
    model_push("R10 after partial discard", 1'b0);

    // R10: writes and pops ignored while held.
    cyc_write(A_CTRL, 32'h1, 1'b0);
    m_wr = 0; m_rd = 0; m_cnt = 0;
    for (int i = 0; i < 4; i++) cyc_write(A_DESC, 32'h5555_0000 + 32'(i), 1'b0);
    check_all("R10 writes ignored while held", 1'b0);
    @(negedge clk); pop_ready = 1'b1;
    @(negedge clk); pop_ready = 1'b0;
    check_all("R10 pop while held no error", 1'b0);
    cyc_write(A_CTRL, 32'h0, 1'b0);
    model_push("R10 push after release", 1'b0);

    // R10: flush pin.
    model_push("R10 pin pre", 1'b0);
    @(negedge clk); ring_clr = 1'b1;
    @(negedge clk); ring_clr = 1'b0;
    m_wr = 0; m_rd = 0; m_cnt = 0;
    check_all("R10 pin flush", 1'b0);

    // R7 / R8 / R9: sticky error, clear, priority.
    model_pop("R7 pop on empty");
    @(negedge clk);
    check("R9 err_evt single cycle", 64'(err_evt), 64'h0);
    cyc_write(A_STAT, 32'h0000_03FF, 1'b0);
    check_all("R8 write without bit10 keeps error", 1'b0);
    cyc_write(A_STAT, 32'h0000_0400, 1'b1);
    check_all("R8 set wins over clear", 1'b1);
    cyc_write(A_STAT, 32'h0000_0400, 1'b0);
    m_err = 1'b0;
    check_all("R8 write one clears error", 1'b0);

    // R6 / R11 / R5: every sequence of six operations from a flushed ring.
    for (int s = 0; s < 729; s++) begin
      int v;
      flush_ring();
      cyc_write(A_STAT, 32'h0000_0400, 1'b0);
      m_err = 1'b0;
      check_all("R8 sweep clear", 1'b0);
      v = s;
      for (int k = 0; k < 6; k++) begin
        case (v % 3)
          0: model_push("R6 sweep push", 1'b0);
          1: model_pop("R3 sweep pop");
          default: model_push("R11 sweep push with pop", 1'b1);
        endcase
        v = v / 3;
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule